// File: doc/BRIEF.md
# Bitslip Serial Word Aligner

The aligner turns nine fast serial lanes into 16-bit parallel sample words. Each lane delivers one bit per fast-clock cycle, least significant bit first, and a word-rate strobe marks the word boundary. Eight lanes carry sample data. The ninth carries a fixed frame marker that shows as 0xFF00 once the boundary is right. One 4-bit slip value picks which of 16 bit offsets starts each word, and it applies to all nine lanes at once. Software sweeps the slip value until the frame lane reads 0xFF00. The data lanes are then aligned as well.

Each lane keeps a 32-bit history of recent bits. On every strobe, a 16-bit window is cut from each history at the offset that the slip value selects, and the result is registered onto the word bus. A slip change waits for the next strobe. The first word captured with a new slip value is marked not valid. A 9-bit fine-delay tap value is registered and passed through for the delay stage that sits outside this block.

Top module: `bitslip_word_aligner`

## Requirements
- R1: With slip 0, the word captured at a strobe holds the 16 bits that arrived in the 16 cycles before the strobe cycle. Bit 0 is the oldest of these bits and bit 15 the newest. The bit present in the strobe cycle itself is not part of that word.
- R2: A slip value s moves the capture window s bits earlier in the stream. Raising s by one rotates the captured frame word left by one bit, so 0x7F80 becomes 0xFF00.
- R3: All nine lanes use the same slip value and the same capture instant. Lane L appears on `words_o[16L+15:16L]`, and lane 8 is the frame lane.
- R4: `frame_ok_o` is high exactly when the frame-lane word on `words_o[143:128]` equals 0xFF00. With a periodic frame marker, exactly one of the 16 slip values gives this match.
- R5: `slip_i` is registered, and a strobe uses the value registered in the cycle before it. If that value differs from the one used at the previous strobe, the word is still captured with the new value but is flagged not valid. The strobes after it are valid again.
- R6: `word_vld_o` pulses for one cycle, in the cycle after a strobe, and only if 32 bits have been shifted in since reset.
- R7: An active-high synchronous reset clears the words, `word_vld_o`, `frame_ok_o`, `tap_o` and the slip offset to 0. Strobes and slip values present during reset have no effect.
- R8: `tap_o` equals the `tap_i` value from the previous cycle.
- R9: Between strobes, `words_o` and `frame_ok_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, one serial bit per lane per cycle |
| rst | input | 1 | Active-high synchronous reset |
| ser_i | input | 9 | Serial bit of each lane; bit 8 is the frame lane |
| word_stb_i | input | 1 | Word-boundary strobe |
| slip_i | input | 4 | Shared word-boundary offset, 0 to 15 |
| tap_i | input | 9 | Fine delay tap, 0 to 511 |
| words_o | output | 144 | Nine captured words, lane L at bits 16L+15:16L |
| word_vld_o | output | 1 | One-cycle pulse after a strobe whose word is valid |
| frame_ok_o | output | 1 | Frame-lane word equals 0xFF00 |
| tap_o | output | 9 | Registered tap value |

## Verification
The bench sweeps all sixteen slip values against a frame marker with a random phase. It checks that each step rotates the frame word left by one and that exactly one slip value raises `frame_ok_o`. An off-by-one window, or a slip that shifts in the wrong direction, would rotate the wrong way or match at the wrong slip value. Random slip changes are made in any cycle, including strobe cycles and cycles just before a strobe. This targets the one-word invalid flag: a design that compared against the live input, or applied the change immediately, would flag the wrong word. The bench also checks the quiet period just after reset, where a missing fill check would raise `word_vld_o` on a partial history.

// File: rtl/wa_pkg.sv
package wa_pkg;
    localparam int          WA_LANES      = 9;
    localparam int          WA_WORD_W     = 16;
    localparam int          WA_TAP_W      = 9;
    localparam logic [15:0] WA_FRAME_WORD = 16'hFF00;
endpackage

// File: rtl/wa_lane_hist.sv
// Per-lane history of the most recent serial bits; newest bit at the top.
module wa_lane_hist #(
    parameter int HIST_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_o
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hist = {bit_i, st_q.hist[HIST_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hist_o = st_q.hist;
endmodule

// File: rtl/wa_word_pick.sv
// Cuts one word out of a lane history; a larger slip reaches further back.
module wa_word_pick #(
    parameter int WORD_W = 16,
    parameter int SLIP_W = 4
) (
    input  logic [2*WORD_W-1:0] hist_i,
    input  logic [SLIP_W-1:0]   slip_i,
    output logic [WORD_W-1:0]   word_o
);
    localparam int BASE_W = SLIP_W + 1;

    logic [BASE_W-1:0] base;

    always_comb begin
        base   = BASE_W'(WORD_W) - BASE_W'(slip_i);
        word_o = hist_i[base +: WORD_W];
    end
endmodule

// File: rtl/wa_slip_ctrl.sv
// Registers the slip request, hands it over at strobes, tracks history fill.
module wa_slip_ctrl #(
    parameter int SLIP_W = 4,
    parameter int HIST_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLIP_W-1:0] slip_i,
    input  logic              stb_i,
    output logic [SLIP_W-1:0] slip_o,
    output logic              good_o
);
    localparam int FILL_W = $clog2(HIST_W + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HIST_W);

    typedef struct packed {
        logic [SLIP_W-1:0] req;
        logic [SLIP_W-1:0] act;
        logic [FILL_W-1:0] fill;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = slip_i;
        if (st_q.fill != FILL_FULL) st_d.fill = st_q.fill + 1'b1;
        if (stb_i) st_d.act = st_q.req;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slip_o = st_q.req;
    assign good_o = (st_q.fill == FILL_FULL) && (st_q.req == st_q.act);
endmodule

// File: rtl/bitslip_word_aligner.sv
module bitslip_word_aligner
    import wa_pkg::*;
#(
    parameter int          LANES      = WA_LANES,
    parameter int          WORD_W     = WA_WORD_W,
    parameter int          TAP_W      = WA_TAP_W,
    parameter logic [15:0] FRAME_WORD = WA_FRAME_WORD
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        ser_i,
    input  logic                    word_stb_i,
    input  logic [$clog2(WORD_W)-1:0] slip_i,
    input  logic [TAP_W-1:0]        tap_i,
    output logic [LANES*WORD_W-1:0] words_o,
    output logic                    word_vld_o,
    output logic                    frame_ok_o,
    output logic [TAP_W-1:0]        tap_o
);
    localparam int SLIP_W    = $clog2(WORD_W);
    localparam int HIST_W    = 2 * WORD_W;
    localparam int BUS_W     = LANES * WORD_W;
    localparam int FRAME_LSB = (LANES - 1) * WORD_W;

    logic [BUS_W-1:0]  pick_bus;
    logic [SLIP_W-1:0] slip_eff;
    logic              cap_good;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [HIST_W-1:0] hist;

            wa_lane_hist #(.HIST_W(HIST_W)) hist_i (
                .clk   (clk),
                .rst   (rst),
                .bit_i (ser_i[g]),
                .hist_o(hist)
            );

            wa_word_pick #(.WORD_W(WORD_W), .SLIP_W(SLIP_W)) pick_i (
                .hist_i(hist),
                .slip_i(slip_eff),
                .word_o(pick_bus[g*WORD_W +: WORD_W])
            );
        end
    endgenerate

    wa_slip_ctrl #(.SLIP_W(SLIP_W), .HIST_W(HIST_W)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .slip_i(slip_i),
        .stb_i (word_stb_i),
        .slip_o(slip_eff),
        .good_o(cap_good)
    );

    typedef struct packed {
        logic [BUS_W-1:0] words;
        logic             vld;
        logic             fok;
        logic [TAP_W-1:0] tap;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.tap = tap_i;
        if (word_stb_i) begin
            st_d.words = pick_bus;
            st_d.vld   = cap_good;
            st_d.fok   = (pick_bus[FRAME_LSB +: WORD_W] == WORD_W'(FRAME_WORD));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign words_o    = st_q.words;
    assign word_vld_o = st_q.vld;
    assign frame_ok_o = st_q.fok;
    assign tap_o      = st_q.tap;
endmodule

// File: rtl/wa_aligner_chk.sv
module wa_aligner_chk #(
    parameter int          LANES      = 9,
    parameter int          WORD_W     = 16,
    parameter int          TAP_W      = 9,
    parameter logic [15:0] FRAME_WORD = 16'hFF00
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      word_stb_i,
    input logic [TAP_W-1:0]          tap_i,
    input logic [LANES*WORD_W-1:0]   words_o,
    input logic                      word_vld_o,
    input logic                      frame_ok_o,
    input logic [TAP_W-1:0]          tap_o
);
    localparam int FRAME_LSB = (LANES - 1) * WORD_W;

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            AST_RESET_QUIET: assert (!word_vld_o && !frame_ok_o && tap_o == '0 && words_o == '0); // R7
        end
    end

    AST_VLD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |-> $past(word_stb_i)); // R6

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(word_stb_i) |-> ($stable(words_o) && $stable(frame_ok_o))); // R9

    AST_FRAME_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        frame_ok_o == (words_o[FRAME_LSB +: WORD_W] == WORD_W'(FRAME_WORD))); // R4

    AST_TAP_PASS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tap_o == $past(tap_i)); // R8
endmodule

bind bitslip_word_aligner wa_aligner_chk #(
    .LANES(LANES), .WORD_W(WORD_W), .TAP_W(TAP_W), .FRAME_WORD(FRAME_WORD)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .word_stb_i(word_stb_i),
    .tap_i     (tap_i),
    .words_o   (words_o),
    .word_vld_o(word_vld_o),
    .frame_ok_o(frame_ok_o),
    .tap_o     (tap_o)
);

// File: tb/bitslip_word_aligner_tb_top.sv
module bitslip_word_aligner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [8:0]   ser_i = '0;
    logic         word_stb_i = 1'b0;
    logic [3:0]   slip_i = '0;
    logic [8:0]   tap_i = '0;
    logic [143:0] words_o;
    logic         word_vld_o;
    logic         frame_ok_o;
    logic [8:0]   tap_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitslip_word_aligner dut_i (
        .clk(clk), .rst(rst), .ser_i(ser_i), .word_stb_i(word_stb_i),
        .slip_i(slip_i), .tap_i(tap_i), .words_o(words_o),
        .word_vld_o(word_vld_o), .frame_ok_o(frame_ok_o), .tap_o(tap_o)
    );

    bit [8:0]     hist_m [0:8191];
    int           cyc = 0;
    int           ph = 0;
    int           n_chk = 0;
    int           n_fail = 0;
    logic [3:0]   req_m = '0;
    logic [3:0]   act_m = '0;
    logic [143:0] exp_words_m = '0;
    logic         exp_fok_m = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(int lane, int c, int s);
        logic [15:0] w;
        for (int k = 0; k < 16; k++) begin
            int idx;
            idx  = c - 16 + k - s;
            w[k] = (idx < 0) ? 1'b0 : hist_m[idx][lane];
        end
        return w;
    endfunction

    function automatic bit frame_bit(int t);
        return ((t + ph) % 16) >= 8;
    endfunction

    // One fast-clock cycle: drive at the falling edge, check just after the rising edge.
    task automatic step(input logic [3:0] slip, input logic [8:0] tap);
        logic [8:0] b;
        logic       stb;
        logic       exp_vld;
        stb = ((cyc % 16) == 15);
        @(negedge clk);
        for (int l = 0; l < 8; l++) b[l] = 1'($urandom % 2);
        b[8]        = frame_bit(cyc);
        hist_m[cyc] = b;
        rst         = 1'b0;
        ser_i       = b;
        word_stb_i  = stb;
        slip_i      = slip;
        tap_i       = tap;
        @(posedge clk);
        #1;
        if (stb) begin
            exp_vld = (cyc >= 32) && (req_m == act_m);
            act_m   = req_m;
            for (int l = 0; l < 9; l++) exp_words_m[l*16 +: 16] = exp_word(l, cyc, int'(req_m));
            exp_fok_m = (exp_words_m[143:128] == 16'hFF00);
            chk(word_vld_o == exp_vld, "R5 R6 valid flag", 144'(word_vld_o), 144'(exp_vld));
            for (int l = 0; l < 9; l++)
                chk(words_o[l*16 +: 16] == exp_words_m[l*16 +: 16], "R1 R2 R3 lane word",
                    144'(words_o[l*16 +: 16]), 144'(exp_words_m[l*16 +: 16]));
            chk(frame_ok_o == exp_fok_m, "R4 frame flag", 144'(frame_ok_o), 144'(exp_fok_m));
        end else begin
            chk(word_vld_o == 1'b0, "R6 no pulse", 144'(word_vld_o), 144'(0));
            chk(words_o == exp_words_m && frame_ok_o == exp_fok_m, "R9 hold",
                words_o, exp_words_m);
        end
        chk(tap_o == tap, "R8 tap", 144'(tap_o), 144'(tap));
        req_m = slip;
        cyc++;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] prev_fw;
        int          fok_cnt;
        logic [3:0]  slip_r;
        void'($urandom(32'd20240517));
        ph = int'($urandom % 16);

        // R7: reset with busy inputs
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            ser_i      = 9'($urandom);
            word_stb_i = 1'b1;
            slip_i     = 4'hA;
            tap_i      = 9'($urandom);
        end
        @(posedge clk);
        #1;
        chk(words_o == '0, "R7 words", words_o, '0);
        chk(word_vld_o == 1'b0 && frame_ok_o == 1'b0, "R7 flags",
            144'({word_vld_o, frame_ok_o}), 144'(0));
        chk(tap_o == '0, "R7 tap", 144'(tap_o), 144'(0));

        // R6: first strobes arrive before the history is full
        for (int i = 0; i < 48; i++) step(4'd0, 9'($urandom));

        // R2 R4: full slip sweep, each slip held for two strobes
        fok_cnt = 0;
        prev_fw = '0;
        for (int s = 0; s < 16; s++) begin
            for (int i = 0; i < 32; i++) step(4'(s), 9'(s * 31));
            if (frame_ok_o) fok_cnt++;
            if (s > 0)
                chk(words_o[143:128] == {prev_fw[14:0], prev_fw[15]}, "R2 rotate left",
                    144'(words_o[143:128]), 144'({prev_fw[14:0], prev_fw[15]}));
            prev_fw = words_o[143:128];
        end
        chk(fok_cnt == 1, "R4 single matching slip", 144'(fok_cnt), 144'(1));

        // R5: change then restore before the strobe keeps the word valid
        slip_r = act_m;
        while ((cyc % 16) != 13) step(slip_r, 9'd0);
        step(slip_r + 4'd1, 9'd1);
        step(slip_r, 9'd2);
        step(slip_r, 9'd3);

        // Random traffic with slip changes in any cycle
        slip_r = 4'($urandom);
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 40) == 0) slip_r = 4'($urandom);
            step(slip_r, 9'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule